// File: doc/BRIEF.md
# Synchronous Burst Access Sequencer

This block is the device-side control sequencer for synchronous burst transfers on a clocked, NOR-flash-style memory bus. A transfer opens when chip enable is low and the address-valid strobe is low on a bus clock edge. On that edge the block captures the start word address and the direction. It then counts an initial latency and steps a word address through the burst, raising a transfer strobe in every cycle where a data word moves. The word address is what drives the memory array.

The configuration inputs choose a fixed length of 4, 8, 16 or 32 words, or a continuous burst. A fixed burst may wrap inside its own aligned block or run sequentially. The latency is fixed or variable. In variable mode, a read that meets a refresh collision at its start gets a longer latency. A burst that steps out of a 128-word row pauses for a parameterised number of clocks before it continues at the next row.

A WAIT output tells the controller when data is not moving. Its active level can be set, and its edges can be placed either on the data cycle itself or one clock ahead of it. A bus clock enable models a stopped bus clock: while it is low the burst is frozen. Taking chip enable high abandons the burst at once.

Top module: `burst_seq`

## Requirements
- R1: A burst starts only on a clock edge where clk_en=1, ce_n=0, adv_n=0 and the configuration is valid. That edge captures addr_in as the first word address. It also captures the direction: xfer_wr=1 when we_n was 0 (write), and xfer_wr=0 when we_n was 1 (read). busy is 1 from the next cycle until the burst ends, and reset clears busy and xfer.
- R2: cfg_len selects the burst length: 001=4, 010=8, 011=16, 100=32 and 111=continuous words. A fixed burst ends with busy=0 straight after its last transfer. A continuous burst keeps running until ce_n rises.
- R3: With cfg_wrap=1 and a fixed length N, each step increments only the low log2(N) address bits, so the burst wraps inside its aligned N-word block. With cfg_wrap=0, or in continuous mode, each step adds one to the word address.
- R4: xfer first goes high in the cycle after the L-th enabled clock edge that follows the capture edge. Here L = cfg_lat + 1.
- R5: In variable mode (cfg_lat_fixed=0), a read that starts with refresh_hit=1 on its capture edge uses L = 2*cfg_lat instead. Writes, and every burst in fixed mode, ignore refresh_hit.
- R6: A start attempt is ignored, leaving busy=0, in any of these cases: cfg_len is 000, 101 or 110; cfg_lat is outside 2..3 in variable mode; or cfg_lat is outside 2..6 in fixed mode.
- R7: A non-wrapping step from an address whose low 7 bits are all ones is a row crossing. It inserts exactly ROW_PAUSE enabled cycles with xfer=0, then continues at the next address.
- R8: With cfg_wait_early=0 and ce_n=0, WAIT is asserted exactly in the cycles where xfer=0. With cfg_wait_early=1, WAIT in each cycle is deasserted exactly when xfer is high in the following enabled cycle.
- R9: The asserted WAIT level equals cfg_wait_hi. While ce_n=1, wait_o shows the deasserted level.
- R10: While clk_en=0 and ce_n=0, the burst state, word_addr and xfer hold their values, and the burst resumes where it stopped.
- R11: On any clock edge where ce_n=1, the burst ends and busy falls, whatever the value of clk_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Bus clock enable; low models a stopped bus clock |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid strobe, active low |
| we_n | input | 1 | Direction at capture: 0 write, 1 read |
| addr_in | input | AW | Start word address |
| refresh_hit | input | 1 | Refresh collision flag, sampled at capture |
| cfg_len | input | 3 | Burst length code |
| cfg_wrap | input | 1 | Wrap within the fixed burst length |
| cfg_lat | input | 3 | Latency code |
| cfg_lat_fixed | input | 1 | 1 fixed latency, 0 variable latency |
| cfg_wait_hi | input | 1 | WAIT asserted level |
| cfg_wait_early | input | 1 | WAIT edges one clock ahead of data |
| wait_o | output | 1 | WAIT indication to the controller |
| xfer | output | 1 | A data word moves in this cycle |
| xfer_wr | output | 1 | Direction of the current burst, 1 write |
| word_addr | output | AW | Current word address to the array |
| busy | output | 1 | A burst is in progress |

## Verification
The bench builds the block with AW=12 and ROW_PAUSE=2, and keeps the 128-word row. The narrow address makes it easy to start bursts just below a row boundary, so wrapping and non-wrapping bursts can be compared at the same spot. A continuous burst runs across a row and is cut short by chip enable. The two-cycle pause keeps each row gap short enough to count exactly. In the same runs, the bench follows the WAIT timing in both placements and both polarities.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_DATA,
        ST_ROW
    } seq_state_e;

    localparam logic [2:0] LEN_W4   = 3'b001;
    localparam logic [2:0] LEN_W8   = 3'b010;
    localparam logic [2:0] LEN_W16  = 3'b011;
    localparam logic [2:0] LEN_W32  = 3'b100;
    localparam logic [2:0] LEN_CONT = 3'b111;

    typedef struct packed {
        logic       wr;
        logic       cont;
        logic       wrap;
        logic [2:0] len_log2;
    } burst_ctx_t;

    function automatic logic len_ok(input logic [2:0] code);
        return (code == LEN_W4) || (code == LEN_W8) || (code == LEN_W16) ||
               (code == LEN_W32) || (code == LEN_CONT);
    endfunction

    function automatic logic lat_ok(input logic [2:0] code, input logic fixed);
        if (fixed)
            return (code >= 3'd2) && (code <= 3'd6);
        return (code == 3'd2) || (code == 3'd3);
    endfunction

    function automatic logic [2:0] len_log2(input logic [2:0] code);
        case (code)
            LEN_W4:  return 3'd2;
            LEN_W8:  return 3'd3;
            LEN_W16: return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic [3:0] lat_clocks(input logic [2:0] code, input logic fixed,
                                              input logic rd, input logic hit);
        if (!fixed && rd && hit)
            return {code, 1'b0};
        return {1'b0, code} + 4'd1;
    endfunction

endpackage

// File: rtl/burst_decode.sv
module burst_decode
    import burst_pkg::*;
(
    input  logic [2:0] cfg_len,
    input  logic       cfg_wrap,
    input  logic [2:0] cfg_lat,
    input  logic       cfg_lat_fixed,
    input  logic       we_n,
    input  logic       refresh_hit,
    output logic       cfg_ok,
    output logic [3:0] lat,
    output burst_ctx_t ctx
);

    logic cont;

    always_comb begin
        cont         = (cfg_len == LEN_CONT);
        cfg_ok       = len_ok(cfg_len) && lat_ok(cfg_lat, cfg_lat_fixed);
        lat          = lat_clocks(cfg_lat, cfg_lat_fixed, we_n, refresh_hit);
        ctx.wr       = !we_n;
        ctx.cont     = cont;
        ctx.wrap     = cfg_wrap && !cont;
        ctx.len_log2 = len_log2(cfg_len);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW       = 21,
    parameter int ROW_BITS = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          wrap,
    input  logic [2:0]    len_log2,
    output logic [AW-1:0] cur,
    output logic          row_end
);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;
    logic [AW-1:0] next_a;

    always_comb begin
        mask    = (AW'(1) << len_log2) - AW'(1);
        inc     = cur + AW'(1);
        next_a  = wrap ? ((cur & ~mask) | (inc & mask)) : inc;
        row_end = (&cur[ROW_BITS-1:0]) && !wrap;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (load)
            cur <= load_addr;
        else if (step)
            cur <= next_a;
    end

    AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (step && wrap) |=> (((cur ^ $past(cur)) & ~$past(mask)) == '0)); // R3

endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
#(
    parameter int CW        = 4,
    parameter int ROW_PAUSE = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ce_n,
    input  logic       adv_n,
    input  logic       cfg_ok,
    input  logic [3:0] lat_in,
    input  burst_ctx_t ctx_in,
    input  logic       row_end,
    output seq_state_e state,
    output logic       load,
    output logic       step,
    output burst_ctx_t ctx,
    output logic       early_valid
);

    localparam logic [CW-1:0] PAUSE_LOAD = CW'(ROW_PAUSE - 1);

    logic [CW-1:0] cnt;
    logic [5:0]    words;
    logic [6:0]    len;
    logic          last;

    always_comb begin
        len  = 7'd1 << ctx.len_log2;
        last = !ctx.cont && ({1'b0, words} == (len - 7'd1));
        load = (state == ST_IDLE) && tick && !ce_n && !adv_n && cfg_ok;
        step = (state == ST_DATA) && tick && !ce_n && !last;
        early_valid = ((state == ST_LAT) && (cnt == '0)) ||
                      ((state == ST_ROW) && (cnt == '0)) ||
                      ((state == ST_DATA) && !last && !row_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            words <= '0;
            ctx   <= '0;
        end else if (ce_n) begin
            state <= ST_IDLE;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        state <= ST_LAT;
                        cnt   <= CW'(lat_in - 4'd1);
                        words <= '0;
                        ctx   <= ctx_in;
                    end
                end
                ST_LAT: begin
                    if (cnt == '0)
                        state <= ST_DATA;
                    else
                        cnt <= cnt - CW'(1);
                end
                ST_DATA: begin
                    if (last) begin
                        state <= ST_IDLE;
                    end else begin
                        words <= words + 6'd1;
                        if (row_end) begin
                            state <= ST_ROW;
                            cnt   <= PAUSE_LOAD;
                        end
                    end
                end
                default: begin
                    if (cnt == '0)
                        state <= ST_DATA;
                    else
                        cnt <= cnt - CW'(1);
                end
            endcase
        end
    end

    AST_CE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (state == ST_IDLE)); // R11

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ce_n) |=> ($stable(state) && $stable(cnt) && $stable(words))); // R10

    AST_ROW_PAUSE: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DATA) && tick && !ce_n && row_end && !last) |=> (state == ST_ROW)); // R7

    AST_FIXED_COUNT: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DATA) && !ctx.cont) |-> ({1'b0, words} < len)); // R2

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int AW        = 21,
    parameter int ROW_WORDS = 128,
    parameter int ROW_PAUSE = 3,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr_in,
    input  logic          refresh_hit,
    input  logic [2:0]    cfg_len,
    input  logic          cfg_wrap,
    input  logic [2:0]    cfg_lat,
    input  logic          cfg_lat_fixed,
    input  logic          cfg_wait_hi,
    input  logic          cfg_wait_early,
    output logic          wait_o,
    output logic          xfer,
    output logic          xfer_wr,
    output logic [AW-1:0] word_addr,
    output logic          busy
);

    localparam int ROW_BITS = $clog2(ROW_WORDS);

    logic       cfg_ok;
    logic [3:0] lat;
    burst_ctx_t ctx_new;
    burst_ctx_t ctx;
    seq_state_e state;
    logic       load;
    logic       step;
    logic       row_end;
    logic       early_valid;
    logic       wait_act;

    burst_decode u_decode (
        .cfg_len       (cfg_len),
        .cfg_wrap      (cfg_wrap),
        .cfg_lat       (cfg_lat),
        .cfg_lat_fixed (cfg_lat_fixed),
        .we_n          (we_n),
        .refresh_hit   (refresh_hit),
        .cfg_ok        (cfg_ok),
        .lat           (lat),
        .ctx           (ctx_new)
    );

    burst_fsm #(
        .CW        (CW),
        .ROW_PAUSE (ROW_PAUSE)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (clk_en),
        .ce_n        (ce_n),
        .adv_n       (adv_n),
        .cfg_ok      (cfg_ok),
        .lat_in      (lat),
        .ctx_in      (ctx_new),
        .row_end     (row_end),
        .state       (state),
        .load        (load),
        .step        (step),
        .ctx         (ctx),
        .early_valid (early_valid)
    );

    burst_addr_gen #(
        .AW       (AW),
        .ROW_BITS (ROW_BITS)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (addr_in),
        .step      (step),
        .wrap      (ctx.wrap),
        .len_log2  (ctx.len_log2),
        .cur       (word_addr),
        .row_end   (row_end)
    );

    always_comb begin
        xfer     = (state == ST_DATA);
        busy     = (state != ST_IDLE);
        xfer_wr  = ctx.wr;
        wait_act = !ce_n && (cfg_wait_early ? !early_valid : !xfer);
        wait_o   = cfg_wait_hi ? wait_act : !wait_act;
    end

    AST_IDLE_WAIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (wait_o == !cfg_wait_hi)); // R9

endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;

    localparam int AW        = 12;
    localparam int ROW_BITS  = 7;
    localparam int ROW_PAUSE = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b1;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          refresh_hit = 1'b0;
    logic [2:0]    cfg_len = 3'b001;
    logic          cfg_wrap = 1'b0;
    logic [2:0]    cfg_lat = 3'd3;
    logic          cfg_lat_fixed = 1'b0;
    logic          cfg_wait_hi = 1'b0;
    logic          cfg_wait_early = 1'b0;
    logic          wait_o;
    logic          xfer;
    logic          xfer_wr;
    logic [AW-1:0] word_addr;
    logic          busy;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    burst_seq #(
        .AW        (AW),
        .ROW_WORDS (128),
        .ROW_PAUSE (ROW_PAUSE),
        .CW        (4)
    ) dut (
        .clk            (clk),
        .rst            (rst),
        .clk_en         (clk_en),
        .ce_n           (ce_n),
        .adv_n          (adv_n),
        .we_n           (we_n),
        .addr_in        (addr_in),
        .refresh_hit    (refresh_hit),
        .cfg_len        (cfg_len),
        .cfg_wrap       (cfg_wrap),
        .cfg_lat        (cfg_lat),
        .cfg_lat_fixed  (cfg_lat_fixed),
        .cfg_wait_hi    (cfg_wait_hi),
        .cfg_wait_early (cfg_wait_early),
        .wait_o         (wait_o),
        .xfer           (xfer),
        .xfer_wr        (xfer_wr),
        .word_addr      (word_addr),
        .busy           (busy)
    );

    always #2.5ns clk = ~clk;

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int len_words(input logic [2:0] c);
        case (c)
            3'b001:  return 4;
            3'b010:  return 8;
            3'b011:  return 16;
            default: return 32;
        endcase
    endfunction

    // R8 timing check at one sample; pw is wait_o of the previous sample
    task automatic wait_chk(input bit pw);
        bit exp;
        if (cfg_wait_early) begin
            exp = xfer ? !cfg_wait_hi : cfg_wait_hi;
            chk(pw == exp, "R8 early wait", int'(pw), int'(exp));
        end else begin
            exp = xfer ? !cfg_wait_hi : cfg_wait_hi;
            chk(wait_o == exp, "R8 wait with data", int'(wait_o), int'(exp));
        end
    endtask

    task automatic set_cfg(input logic [2:0] len, input bit wrap, input logic [2:0] lat,
                           input bit fixed, input bit hi, input bit early);
        cfg_len = len; cfg_wrap = wrap; cfg_lat = lat;
        cfg_lat_fixed = fixed; cfg_wait_hi = hi; cfg_wait_early = early;
    endtask

    task automatic burst(input logic [AW-1:0] a, input bit wr, input bit hit, input int lat,
                         input int nwords, input int susp_at, input string ltag);
        logic [AW-1:0] ea;
        int k;
        int got;
        int gap;
        int egap;
        bit pw;
        int lenw;
        bit wrap_on;
        bit cont;
        cont    = (cfg_len == 3'b111);
        lenw    = len_words(cfg_len);
        wrap_on = cfg_wrap && !cont;
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; addr_in = a; we_n = !wr; refresh_hit = hit; clk_en = 1'b1;
        @(negedge clk);
        adv_n = 1'b1; refresh_hit = 1'b0; addr_in = '0;
        chk(busy, "R1 busy after capture", int'(busy), 1);
        k = 0;
        pw = wait_o;
        while (!xfer && k < 40) begin
            @(negedge clk);
            k++;
            wait_chk(pw);
            pw = wait_o;
        end
        chk(k == lat, {ltag, " first transfer latency"}, k, lat);
        chk(xfer_wr == wr, "R1 direction", int'(xfer_wr), int'(wr));
        ea = a; got = 0; gap = 0; egap = 0;
        while (got < nwords && gap < 20) begin
            if (xfer) begin
                if (got > 0)
                    chk(gap == egap, "R7 row pause length", gap, egap);
                chk(word_addr == ea, "R3 word address", int'(word_addr), int'(ea));
                if (got == susp_at) begin
                    clk_en = 1'b0;
                    repeat (3) begin
                        @(negedge clk);
                        chk(xfer && word_addr == ea, "R10 suspended hold", int'(word_addr), int'(ea));
                    end
                    clk_en = 1'b1;
                    pw = wait_o;
                end
                egap = (!wrap_on && ea[ROW_BITS-1:0] == '1) ? ROW_PAUSE : 0;
                ea   = wrap_on ? ((ea & ~AW'(lenw - 1)) | ((ea + AW'(1)) & AW'(lenw - 1)))
                               : ea + AW'(1);
                got++;
                gap = 0;
            end else begin
                gap++;
            end
            @(negedge clk);
            wait_chk(pw);
            pw = wait_o;
        end
        chk(got == nwords, "R2 transfer count", got, nwords);
        if (cont) begin
            chk(busy, "R2 continuous still running", int'(busy), 1);
            ce_n = 1'b1;
            @(negedge clk);
            chk(!busy && !xfer, "R11 ce high ends continuous burst", int'(busy), 0);
        end else begin
            chk(!busy && !xfer, "R2 fixed burst ends", int'(busy), 0);
        end
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy, "R1 reset busy", int'(busy), 0);
        chk(!xfer, "R1 reset xfer", int'(xfer), 0);
        chk(wait_o == 1'b1, "R9 deasserted level with ce high", int'(wait_o), 1);
    endtask

    task automatic t_wrap4();
        set_cfg(3'b001, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
        burst(12'h0A6, 1'b0, 1'b0, 3, 4, -1, "R4");
    endtask

    task automatic t_write8();
        set_cfg(3'b010, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
        burst(12'h010, 1'b1, 1'b0, 4, 8, -1, "R4");
    endtask

    task automatic t_collide();
        set_cfg(3'b001, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
        burst(12'h200, 1'b0, 1'b1, 6, 4, -1, "R5");
        set_cfg(3'b001, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0);
        burst(12'h204, 1'b0, 1'b1, 4, 4, -1, "R5");
        burst(12'h208, 1'b1, 1'b1, 3, 4, -1, "R5");
    endtask

    task automatic t_fixed();
        set_cfg(3'b001, 1'b0, 3'd6, 1'b1, 1'b0, 1'b0);
        burst(12'h300, 1'b0, 1'b1, 7, 4, -1, "R5");
        set_cfg(3'b010, 1'b0, 3'd4, 1'b1, 1'b0, 1'b0);
        burst(12'h310, 1'b0, 1'b0, 5, 8, -1, "R4");
    endtask

    task automatic t_row();
        set_cfg(3'b011, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0);
        burst(12'h07C, 1'b0, 1'b0, 3, 16, -1, "R4");
    endtask

    task automatic t_wrap32();
        set_cfg(3'b100, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
        burst(12'h07E, 1'b0, 1'b0, 3, 32, -1, "R4");
    endtask

    task automatic t_cont();
        set_cfg(3'b111, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0);
        burst(12'h0FD, 1'b1, 1'b0, 4, 8, -1, "R4");
    endtask

    task automatic t_early();
        set_cfg(3'b001, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1);
        burst(12'h17E, 1'b0, 1'b0, 3, 4, -1, "R4");
        @(negedge clk);
        chk(wait_o == 1'b0, "R9 active-high deasserted with ce high", int'(wait_o), 0);
    endtask

    task automatic t_suspend();
        set_cfg(3'b010, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
        burst(12'h400, 1'b0, 1'b0, 4, 8, 2, "R4");
    endtask

    task automatic t_ce_abort();
        set_cfg(3'b010, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; addr_in = 12'h500;
        @(negedge clk);
        adv_n = 1'b1;
        chk(busy, "R1 abort burst started", int'(busy), 1);
        clk_en = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        chk(!busy && !xfer, "R11 ce high with clock stopped", int'(busy), 0);
        clk_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic try_reject(input string tag);
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; addr_in = 12'h600;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!busy && !xfer, tag, int'(busy), 0);
        end
        ce_n = 1'b1; adv_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reserved();
        set_cfg(3'b000, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
        try_reject("R6 length code 000 rejected");
        set_cfg(3'b101, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0);
        try_reject("R6 length code 101 rejected");
        set_cfg(3'b010, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0);
        try_reject("R6 variable latency code 4 rejected");
        set_cfg(3'b010, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0);
        try_reject("R6 fixed latency code 7 rejected");
    endtask

    initial begin
        #500us;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wrap4();
        t_write8();
        t_collide();
        t_fixed();
        t_row();
        t_wrap32();
        t_cont();
        t_early();
        t_suspend();
        t_ce_abort();
        t_reserved();
        report();
        $finish;
    end

endmodule